// File: doc/BRIEF.md
# Power-On and Brownout Reset Sequencer

This block merges four reset origins (supply monitor, watchdog, external pin, internal request) into one system reset and controls when that reset is let go. It runs on the fast oscillator clock, which keeps toggling while the system is held in reset; only instruction execution is blocked. A supply-OK flag from an analog comparator, a watchdog reset pulse, an already synchronized external reset level and an internal reset request come in. The system reset, a one-cycle strobe that loads the program counter with the start address 8000h, and four sticky cause flags go out.

A low supply flag always wins. Whenever the flag rises, a fixed count of 65,536 oscillator cycles must pass with the supply still good before reset is released. A brownout during operation, or a supply dip during that count, restarts the whole sequence from zero, exactly as at first power-up. The external pin holds reset for as long as it is asserted. Watchdog and internal requests give a short fixed hold of 4 cycles. Whatever the origin, the held state is the same: system reset high and no start strobe.

Top module: `por_reset_sequencer`

## Requirements
- R1: While the block's own reset `rst_n_i` is low, and in the first cycle after it, `sys_rst_o` is 1, `start_load_o` is 0 and `cause_o` is 4'b0001.
- R2: While `supply_ok_i` is 0, `sys_rst_o` stays 1 and `cause_o` is 4'b0001 from the next cycle on, whatever the watchdog, pin, internal and clear inputs do.
- R3: With the block holding reset for the supply, `sys_rst_o` goes low only after `supply_ok_i` has been sampled high on 65,536 consecutive rising edges. It is 0 in the cycle that follows the 65,536th such edge and 1 before it.
- R4: Every release of reset produces exactly one cycle of `start_load_o`, in the first cycle with `sys_rst_o` low, and `start_addr_o` is 16'h8000 in that cycle.
- R5: With the system running, `ext_rst_i` high holds `sys_rst_o` at 1 from the next cycle for as long as the pin stays high. Release follows in the cycle after the first edge that samples it low, with no 65,536-cycle delay.
- R6: A low `supply_ok_i`, seen while running or part-way through the delay count, discards any count already made. The next rise needs the full 65,536 cycles again.
- R7: A one-cycle `wdt_rst_i` or `int_rst_req_i` while running holds `sys_rst_o` at 1 for exactly 4 cycles, starting in the next cycle.
- R8: `cause_o` bit 0 marks supply, bit 1 watchdog, bit 2 external pin and bit 3 internal request. Each new reset replaces all flags with the single bit of its origin.
- R9: Writing 1 to a bit of `cause_clr_i` clears that flag in the next cycle, and bits written 0 are unchanged. If a new reset sets flags in the same cycle, the set wins.
- R10: When origins coincide, the priority is supply, then external pin, then watchdog, then internal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast oscillator clock |
| rst_n_i | input | 1 | Synchronous active-low initialisation of the block |
| supply_ok_i | input | 1 | Supply comparator result, 1 = supply in tolerance |
| wdt_rst_i | input | 1 | Watchdog reset pulse |
| ext_rst_i | input | 1 | Synchronized external reset level, 1 = hold reset |
| int_rst_req_i | input | 1 | Internal system reset request |
| cause_clr_i | input | 4 | Write-one-to-clear mask for the cause flags |
| sys_rst_o | output | 1 | System reset, 1 = held in reset |
| start_load_o | output | 1 | One-cycle strobe to load the start address |
| start_addr_o | output | 16 | Start address, 16'h8000 |
| cause_o | output | 4 | Sticky cause flags (see R8) |

## Verification
The bench restarts the power-on count with a short supply dip after 1,000 cycles, and later forces a brownout while the system is running. A design that kept a partial count would release about 1,000 cycles early, and one that skipped the delay after a brownout would release within a few cycles. The release edge is compared to the exact cycle, so an off-by-one count shows up as a wrong release cycle. Coincident pin, watchdog and internal requests, together with a flag clear issued in the same cycle as a new cause, expose a wrong priority or a clear that overrides a set. Activity on the other reset inputs during a brownout shows whether the supply hold can be displaced.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
// rsq_pkg: shared types and cause-bit positions for the reset sequencer.
// Assumes a cause vector of four bits, one per reset origin.
package rsq_pkg;
    localparam int CAUSE_W   = 4;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_WDT = 1;
    localparam int CAUSE_EXT = 2;
    localparam int CAUSE_INT = 3;

    typedef enum logic [1:0] {
        SEQ_POWER = 2'd0,   // held for supply, delay counting
        SEQ_RUN   = 2'd1,   // reset released
        SEQ_PULSE = 2'd2,   // short fixed hold (watchdog / internal)
        SEQ_PIN   = 2'd3    // held by external pin
    } seq_state_e;
endpackage

// File: rtl/rsq_counter.sv
`timescale 1ns/1ps
// rsq_counter: up-counter with synchronous clear and enable.
// Assumes the controller never enables it beyond its terminal value.
module rsq_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Count cycles; clear wins over enable.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)   cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else if (en_i)  cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/rsq_cause_reg.sv
`timescale 1ns/1ps
// rsq_cause_reg: sticky reset-cause flags. A set replaces the whole
// vector; otherwise set bits of the clear mask are removed.
// Assumes set_val_i is one-hot whenever set_vld_i is high.
module rsq_cause_reg
    import rsq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               set_vld_i,
    input  logic [CAUSE_W-1:0] set_val_i,
    input  logic [CAUSE_W-1:0] clr_mask_i,
    output logic [CAUSE_W-1:0] flags_o
);
    localparam logic [CAUSE_W-1:0] POR_ONLY = CAUSE_W'(1) << CAUSE_POR;

    // Hold flags: new cause replaces, else write-one-to-clear.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)       flags_o <= POR_ONLY;
        else if (set_vld_i) flags_o <= set_val_i;
        else                flags_o <= flags_o & ~clr_mask_i;
    end
endmodule

// File: rtl/rsq_fsm.sv
`timescale 1ns/1ps
// rsq_fsm: sequencing state machine. Chooses the hold reason by priority
// (supply > pin > watchdog > internal), drives the shared counter and
// reports the cause to record and the entry into the run state.
// Assumes ext_i is already synchronized to clk_i.
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int CNT_W = 17,
    parameter logic [CNT_W-1:0] POR_LAST   = '1,
    parameter logic [CNT_W-1:0] PULSE_LAST = '1
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               supply_ok_i,
    input  logic               wdt_i,
    input  logic               ext_i,
    input  logic               intr_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output seq_state_e         state_o,
    output logic               cnt_clr_o,
    output logic               cnt_en_o,
    output logic               set_vld_o,
    output logic [CAUSE_W-1:0] set_val_o,
    output logic               enter_run_o
);
    localparam logic [CAUSE_W-1:0] BIT_POR = CAUSE_W'(1) << CAUSE_POR;
    localparam logic [CAUSE_W-1:0] BIT_WDT = CAUSE_W'(1) << CAUSE_WDT;
    localparam logic [CAUSE_W-1:0] BIT_EXT = CAUSE_W'(1) << CAUSE_EXT;
    localparam logic [CAUSE_W-1:0] BIT_INT = CAUSE_W'(1) << CAUSE_INT;

    seq_state_e nxt;

    // Next state, counter control and cause selection.
    always_comb begin
        nxt       = state_o;
        cnt_clr_o = 1'b0;
        cnt_en_o  = 1'b0;
        set_vld_o = 1'b0;
        set_val_o = '0;
        if (!supply_ok_i) begin
            nxt       = SEQ_POWER;
            cnt_clr_o = 1'b1;
            set_vld_o = 1'b1;
            set_val_o = BIT_POR;
        end else begin
            case (state_o)
                SEQ_POWER: begin
                    if (cnt_i == POR_LAST) begin
                        nxt       = ext_i ? SEQ_PIN : SEQ_RUN;
                        cnt_clr_o = 1'b1;
                    end else begin
                        cnt_en_o = 1'b1;
                    end
                end
                SEQ_RUN: begin
                    cnt_clr_o = 1'b1;
                    if (ext_i) begin
                        nxt = SEQ_PIN;   set_vld_o = 1'b1; set_val_o = BIT_EXT;
                    end else if (wdt_i) begin
                        nxt = SEQ_PULSE; set_vld_o = 1'b1; set_val_o = BIT_WDT;
                    end else if (intr_i) begin
                        nxt = SEQ_PULSE; set_vld_o = 1'b1; set_val_o = BIT_INT;
                    end
                end
                SEQ_PULSE: begin
                    if (ext_i) begin
                        nxt = SEQ_PIN; cnt_clr_o = 1'b1;
                        set_vld_o = 1'b1; set_val_o = BIT_EXT;
                    end else if (cnt_i == PULSE_LAST) begin
                        nxt = SEQ_RUN; cnt_clr_o = 1'b1;
                    end else begin
                        cnt_en_o = 1'b1;
                    end
                end
                SEQ_PIN: begin
                    cnt_clr_o = 1'b1;
                    if (!ext_i) nxt = SEQ_RUN;
                end
                default: nxt = SEQ_POWER;
            endcase
        end
    end

    assign enter_run_o = (nxt == SEQ_RUN) && (state_o != SEQ_RUN);

    // State register; block reset starts a power-on sequence.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_o <= SEQ_POWER;
        else          state_o <= nxt;
    end
endmodule

// File: rtl/por_reset_sequencer.sv
`timescale 1ns/1ps
// por_reset_sequencer: merges supply, watchdog, pin and internal resets
// into one system reset, applies the power-on delay, pulses the start
// address load on release and keeps sticky cause flags.
// Assumes all inputs are synchronous to clk_i.
module por_reset_sequencer
    import rsq_pkg::*;
#(
    parameter int POR_CYCLES   = 65536,
    parameter int PULSE_CYCLES = 4,
    parameter int ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] START_ADDR = 16'h8000
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               supply_ok_i,
    input  logic               wdt_rst_i,
    input  logic               ext_rst_i,
    input  logic               int_rst_req_i,
    input  logic [3:0]         cause_clr_i,
    output logic               sys_rst_o,
    output logic               start_load_o,
    output logic [ADDR_W-1:0]  start_addr_o,
    output logic [3:0]         cause_o
);
    localparam int MAX_CYC = (POR_CYCLES > PULSE_CYCLES) ? POR_CYCLES : PULSE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYCLES - 1);

    seq_state_e         state;
    logic               cnt_clr, cnt_en, set_vld, enter_run;
    logic [CNT_W-1:0]   cnt;
    logic [CAUSE_W-1:0] set_val;
    logic               start_q;

    rsq_fsm #(
        .CNT_W(CNT_W), .POR_LAST(POR_LAST), .PULSE_LAST(PULSE_LAST)
    ) u_fsm (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .supply_ok_i(supply_ok_i),
        .wdt_i(wdt_rst_i), .ext_i(ext_rst_i), .intr_i(int_rst_req_i),
        .cnt_i(cnt), .state_o(state), .cnt_clr_o(cnt_clr), .cnt_en_o(cnt_en),
        .set_vld_o(set_vld), .set_val_o(set_val), .enter_run_o(enter_run)
    );

    rsq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(cnt_clr), .en_i(cnt_en),
        .cnt_o(cnt)
    );

    rsq_cause_reg u_cause (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .set_vld_i(set_vld),
        .set_val_i(set_val), .clr_mask_i(cause_clr_i), .flags_o(cause_o)
    );

    // Register the start strobe so it lands in the first released cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) start_q <= 1'b0;
        else          start_q <= enter_run;
    end

    assign sys_rst_o    = (state != SEQ_RUN);
    assign start_load_o = start_q;
    assign start_addr_o = START_ADDR;
endmodule

// File: rtl/por_reset_sequencer_chk.sv
`timescale 1ns/1ps
// por_reset_sequencer_chk: port-level properties of the sequencer.
// Assumes it is bound to every instance of por_reset_sequencer.
module por_reset_sequencer_chk #(
    parameter int PULSE_CYCLES = 4
) (
    input logic       clk_i,
    input logic       rst_n_i,
    input logic       supply_ok_i,
    input logic       wdt_rst_i,
    input logic       ext_rst_i,
    input logic       int_rst_req_i,
    input logic       sys_rst_o,
    input logic       start_load_o,
    input logic [3:0] cause_o
);
    int unsigned short_hold;

    // Track how long a watchdog/internal hold has lasted.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                                 short_hold <= 0;
        else if (sys_rst_o && (cause_o[1] || cause_o[3])) short_hold <= short_hold + 1;
        else                                          short_hold <= 0;
    end

    a_r2_supply_low_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !supply_ok_i |=> (sys_rst_o && cause_o == 4'b0001));
    a_r4_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        start_load_o |=> !start_load_o);
    a_r4_strobe_released: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        start_load_o |-> !sys_rst_o);
    a_r4_release_strobes: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(sys_rst_o) |-> start_load_o);
    a_r5_pin_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ext_rst_i && supply_ok_i) |=> sys_rst_o);
    a_r7_short_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        short_hold <= PULSE_CYCLES);
    a_r7_short_starts: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!sys_rst_o && supply_ok_i && (wdt_rst_i || int_rst_req_i)) |=> sys_rst_o);
    a_r8_single_cause: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0(cause_o));
endmodule

bind por_reset_sequencer por_reset_sequencer_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .supply_ok_i(supply_ok_i),
    .wdt_rst_i(wdt_rst_i), .ext_rst_i(ext_rst_i), .int_rst_req_i(int_rst_req_i),
    .sys_rst_o(sys_rst_o), .start_load_o(start_load_o), .cause_o(cause_o)
);

// File: tb/por_reset_sequencer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected releases, a monitor pops
// one per start strobe and compares cycle, cause and address.
module por_reset_sequencer_test;
    localparam int DELAY = 65536;
    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b0, wdt = 1'b0, ext = 1'b0, intr = 1'b0;
    logic [3:0]  clr = 4'b0;
    logic        sys_rst, start_load;
    logic [15:0] start_addr;
    logic [3:0]  cause;

    int n_cmp = 0, n_bad = 0;
    int unsigned cyc = 0;
    bit done = 0;

    typedef struct packed { int unsigned at; logic [3:0] cause; } exp_t;
    exp_t sb_q[$];
    exp_t mon_e;

    por_reset_sequencer uut (
        .clk_i(clk), .rst_n_i(rst_n), .supply_ok_i(supply_ok), .wdt_rst_i(wdt),
        .ext_rst_i(ext), .int_rst_req_i(intr), .cause_clr_i(clr),
        .sys_rst_o(sys_rst), .start_load_o(start_load), .start_addr_o(start_addr),
        .cause_o(cause)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: each strobe consumes one expected release.
    always @(negedge clk) begin
        if (rst_n && start_load) begin
            if (sb_q.size() == 0) chk("R4 unexpected strobe", 1, 0);
            else begin
                mon_e = sb_q.pop_front();
                chk("R3/R5/R7 release cycle", cyc, mon_e.at);
                chk("R8 cause at release", {28'd0, cause}, {28'd0, mon_e.cause});
                chk("R4 start address", {16'd0, start_addr}, 32'h8000);
            end
        end
    end

    // Short hold from watchdog or internal source (R7).
    task automatic short_reset(input bit use_wdt, input logic [3:0] exp_cause);
        sb_q.push_back('{at: cyc + 5, cause: exp_cause});
        wdt = use_wdt; intr = !use_wdt;
        @(negedge clk); wdt = 0; intr = 0;
        for (int i = 0; i < 4; i++) begin
            chk("R7 short hold", sys_rst, 1);
            if (i < 3) @(negedge clk);
        end
        @(negedge clk);
        chk("R7 short release", sys_rst, 0);
    endtask

    // Pin hold of n cycles, optionally with coincident other sources (R5, R10).
    task automatic pin_reset(input int n, input bit others);
        sb_q.push_back('{at: cyc + n + 1, cause: 4'b0100});
        ext = 1; wdt = others; intr = others;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wdt = 0; intr = 0;
            chk("R5 pin hold", sys_rst, 1);
        end
        ext = 0;
        @(negedge clk);
        chk("R5 pin release", sys_rst, 0);
        chk("R10 pin beats watchdog/internal", {28'd0, cause}, 32'h4);
    endtask

    // Supply rise and full delay (R3).
    task automatic power_up();
        supply_ok = 1;
        sb_q.push_back('{at: cyc + DELAY, cause: 4'b0001});
        repeat (DELAY - 1) @(negedge clk);
        chk("R3 still held one cycle before", sys_rst, 1);
        @(negedge clk);
        chk("R3 released after delay", sys_rst, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset holds", sys_rst, 1);
        chk("R1 reset cause", {28'd0, cause}, 32'h1);
        chk("R1 no strobe", start_load, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", sys_rst, 1);
        chk("R1 cause after reset", {28'd0, cause}, 32'h1);
        // R2: supply low holds even with pin/watchdog activity
        wdt = 1; ext = 1; clr = 4'hF;
        @(negedge clk); wdt = 0; ext = 0;
        repeat (10) @(negedge clk);
        chk("R2 supply low holds", sys_rst, 1);
        chk("R2 cause stays supply", {28'd0, cause}, 32'h1);
        clr = 4'h0;
        // R6: dip part-way through the count restarts it
        supply_ok = 1;
        repeat (1000) @(negedge clk);
        chk("R3 mid count", sys_rst, 1);
        supply_ok = 0;
        repeat (3) @(negedge clk);
        chk("R6 dip holds", sys_rst, 1);
        chk("R6 dip cause", {28'd0, cause}, 32'h1);
        power_up();
        // R9: write-one-to-clear
        clr = 4'b0010;
        @(negedge clk); clr = 0;
        chk("R9 zero-bit write keeps flag", {28'd0, cause}, 32'h1);
        clr = 4'b0001;
        @(negedge clk); clr = 0;
        chk("R9 clear by one", {28'd0, cause}, 32'h0);
        short_reset(1'b1, 4'b0010);
        short_reset(1'b0, 4'b1000);
        // R10: watchdog beats internal when both arrive together
        wdt = 1; intr = 1;
        sb_q.push_back('{at: cyc + 5, cause: 4'b0010});
        @(negedge clk); wdt = 0; intr = 0;
        chk("R10 watchdog beats internal", {28'd0, cause}, 32'h2);
        repeat (4) @(negedge clk);
        // R9: set wins over same-cycle clear
        clr = 4'b1010; intr = 1;
        sb_q.push_back('{at: cyc + 5, cause: 4'b1000});
        @(negedge clk); clr = 0; intr = 0;
        chk("R9 set wins over clear", {28'd0, cause}, 32'h8);
        repeat (4) @(negedge clk);
        pin_reset(12, 1'b0);
        pin_reset(5, 1'b1);
        // R6: brownout while running, R10 supply beats pin
        supply_ok = 0; ext = 1; wdt = 1;
        @(negedge clk); wdt = 0;
        chk("R6 brownout asserts reset", sys_rst, 1);
        chk("R10 supply beats pin", {28'd0, cause}, 32'h1);
        repeat (4) @(negedge clk);
        ext = 0;
        power_up();
        repeat (3) @(negedge clk);
        chk("R4 all releases seen", sb_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= LIMIT);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule